// File: doc/BRIEF.md
# Prioritized Interrupt Presentation Controller

This block is an interrupt controller for a single processor core. It accepts N request lines. Each line has its own priority, vector, mask bit, edge or level sensitivity and destination. Requests are latched as pending. The controller then picks the unmasked pending source with the highest priority among those routed to the core. It presents that source on the core interrupt output only if its priority is above both the core's task priority and every interrupt already in service.

Software works through three strobes. An acknowledge read returns the vector of the presented source, or a programmable spurious vector when nothing is eligible. The same read drops the interrupt line and marks the source as in service. An end-of-interrupt write retires the most important source in service. Level-sensitive sources can also be steered to a critical output or to an external request pin. These two paths do not use the task priority or the in-service state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the following hold:
  - `int_o`, `cint_o` and `ext_irq_o` are low and `act_o` is zero.
  - Every source has priority 0, vector 0, mask set, edge sensitivity and destination code 0.
  - The task priority is 0 and the spurious vector is all ones.
- R2: `int_o` is high in a cycle only when, one clock earlier, the best eligible source had a priority strictly greater than the task priority and strictly greater than the highest in-service priority. An eligible source is pending, unmasked, has nonzero priority, destination code 0 and is not in service. Edge pending is set one clock after a 0-to-1 input change. Level pending follows the input one clock late.
- R3: Among eligible sources, the one with the highest priority wins. On equal priority the lowest index wins.
- R4: An acknowledge read while a source is presented has three effects:
  - It returns that source's vector on `iack_data` in the same cycle.
  - It forces `int_o` low on the next clock.
  - It puts the source in service.
- R5: An acknowledge read with no presented source returns the spurious vector (written with `spur_we`) and leaves the in-service state unchanged.
- R6: An end-of-interrupt write removes from service the in-service source with the highest priority, ties to the lowest index.
- R7: A masked source, or a source with priority 0, never raises any output.
- R8: An acknowledge clears the pending state of an edge-sensitive source. A level-sensitive source stays pending while its input is high, so after its end-of-interrupt it is presented again.
- R9: A change to task priority, mask or priority reaches `int_o` exactly one clock after the register write takes effect.
- R10: Destination code 1 routes a source to `cint_o` and code 2 routes it to `ext_irq_o`. Each of these outputs goes high one clock after a qualifying source is pending. A qualifying source is level-sensitive, unmasked and has nonzero priority. Edge-configured sources with those codes drive nothing, and no source with code 1 or 2 drives `int_o`.
- R11: `act_o[i]` is 1 exactly while source i is pending or in service.
- R12: A source of lower or equal priority than one in service is held off until that service ends, while a strictly higher one nests on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N | Request lines, one per source |
| cfg_we | input | 1 | Write strobe for the configuration of source `cfg_sel` |
| cfg_sel | input | IW | Source index being configured |
| cfg_pri | input | PW | Priority to write (0 = never interrupts) |
| cfg_vec | input | VW | Vector to write |
| cfg_msk | input | 1 | Mask bit to write (1 = masked) |
| cfg_lvl | input | 1 | Sensitivity to write (1 = level, 0 = edge) |
| cfg_dst | input | 2 | Destination: 0 core, 1 critical, 2 external, 3 undefined |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | PW | Task priority value |
| spur_we | input | 1 | Spurious vector write strobe |
| spur_wdata | input | VW | Spurious vector value |
| iack_re | input | 1 | Acknowledge read strobe |
| iack_data | output | VW | Vector returned by the acknowledge read |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| int_o | output | 1 | Core interrupt request |
| cint_o | output | 1 | Critical interrupt output |
| ext_irq_o | output | 1 | External interrupt request pin |
| act_o | output | N | Per-source activity (pending or in service) |

## Verification
The hardest state to reach is a stack of two interrupts in service with a third, lower one pending and held off. The controller must retire the stack in priority order and only then present the held request. The bench reaches it step by step:
1. It pulses a low-priority edge source and acknowledges it.
2. It pulses a higher source, which nests, and acknowledges that too.
3. It pulses a source below both.
4. It issues end-of-interrupt writes one at a time, watching the activity bits and the interrupt line after each.

Priority selection and the strict task-priority compare are swept over every priority and task-priority pair, and over tie-heavy patterns across all sources.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    DST_CORE = 2'd0,
    DST_CRIT = 2'd1,
    DST_EXT  = 2'd2,
    DST_RSVD = 2'd3
  } dst_e;
endpackage

// File: rtl/pic_pick.sv
// Combinational highest-priority picker; ties resolve to the lowest index.
module pic_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] pri,
  output logic                 found,
  output logic [IW-1:0]        idx,
  output logic [PW-1:0]        best
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (pri[i] > best))) begin
        found = 1'b1;
        best  = pri[i];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_src_bank.sv
// Per-source configuration registers and pending capture.
module pic_src_bank #(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int VW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         src_in,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_sel,
  input  logic [PW-1:0]        cfg_pri,
  input  logic [VW-1:0]        cfg_vec,
  input  logic                 cfg_msk,
  input  logic                 cfg_lvl,
  input  logic [1:0]           cfg_dst,
  input  logic [N-1:0]         ack_clr,
  output logic [N-1:0][PW-1:0] pri_o,
  output logic [N-1:0][VW-1:0] vec_o,
  output logic [N-1:0]         msk_o,
  output logic [N-1:0]         lvl_o,
  output logic [N-1:0][1:0]    dst_o,
  output logic [N-1:0]         pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic cfg_en;
    assign cfg_en = cfg_we && (cfg_sel == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pri_o[i] <= '0;
        vec_o[i] <= '0;
        msk_o[i] <= 1'b1;
        lvl_o[i] <= 1'b0;
        dst_o[i] <= 2'd0;
      end else if (cfg_en) begin
        pri_o[i] <= cfg_pri;
        vec_o[i] <= cfg_vec;
        msk_o[i] <= cfg_msk;
        lvl_o[i] <= cfg_lvl;
        dst_o[i] <= cfg_dst;
      end
    end

    always_comb begin
      if (lvl_o[i]) pend_d[i] = src_in[i];
      else          pend_d[i] = (pend_o[i] && !ack_clr[i]) || (src_in[i] && !prev_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_o[i] <= 1'b0;
      end else begin
        prev_q[i] <= src_in[i];
        pend_o[i] <= pend_d[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int VW = 8,
  parameter logic [VW-1:0] SPUR_RST = '1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_in,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_sel,
  input  logic [PW-1:0] cfg_pri,
  input  logic [VW-1:0] cfg_vec,
  input  logic          cfg_msk,
  input  logic          cfg_lvl,
  input  logic [1:0]    cfg_dst,
  input  logic          tpr_we,
  input  logic [PW-1:0] tpr_wdata,
  input  logic          spur_we,
  input  logic [VW-1:0] spur_wdata,
  input  logic          iack_re,
  output logic [VW-1:0] iack_data,
  input  logic          eoi_we,
  output logic          int_o,
  output logic          cint_o,
  output logic          ext_irq_o,
  output logic [N-1:0]  act_o
);
  logic [N-1:0][PW-1:0] pri_w;
  logic [N-1:0][VW-1:0] vec_w;
  logic [N-1:0]         msk_w, lvl_w, pend_w;
  logic [N-1:0][1:0]    dst_w;
  logic [N-1:0]         isr_q, isr_d, core_req, crit_req, ext_req, ack_clr;
  logic [PW-1:0]        tpr_q;
  logic [VW-1:0]        spur_q;
  logic                 int_q, int_d, cint_q, cint_d, ext_q, ext_d;
  logic                 win_v, is_v, int_ok, ack_hit;
  logic [IW-1:0]        win_idx, is_idx;
  logic [PW-1:0]        win_pri, is_pri;

  pic_src_bank #(.N(N), .PW(PW), .VW(VW)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_pri(cfg_pri), .cfg_vec(cfg_vec),
    .cfg_msk(cfg_msk), .cfg_lvl(cfg_lvl), .cfg_dst(cfg_dst), .ack_clr(ack_clr),
    .pri_o(pri_w), .vec_o(vec_w), .msk_o(msk_w), .lvl_o(lvl_w), .dst_o(dst_w),
    .pend_o(pend_w)
  );

  // Eligibility per destination.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic live;
      live        = pend_w[i] && !msk_w[i] && (pri_w[i] != '0);
      core_req[i] = live && (dst_w[i] == 2'(DST_CORE)) && !isr_q[i];
      crit_req[i] = live && lvl_w[i] && (dst_w[i] == 2'(DST_CRIT));
      ext_req[i]  = live && lvl_w[i] && (dst_w[i] == 2'(DST_EXT));
    end
  end

  pic_pick #(.N(N), .PW(PW)) u_pick_pend (
    .req(core_req), .pri(pri_w), .found(win_v), .idx(win_idx), .best(win_pri)
  );

  pic_pick #(.N(N), .PW(PW)) u_pick_isr (
    .req(isr_q), .pri(pri_w), .found(is_v), .idx(is_idx), .best(is_pri)
  );

  // Presentation decision and acknowledge / end-of-interrupt next state.
  always_comb begin
    int_ok    = win_v && (win_pri > tpr_q) && (!is_v || (win_pri > is_pri));
    ack_hit   = iack_re && int_ok;
    iack_data = ack_hit ? vec_w[win_idx] : spur_q;
    ack_clr   = '0;
    isr_d     = isr_q;
    if (eoi_we && is_v) isr_d[is_idx] = 1'b0;
    if (ack_hit) begin
      ack_clr[win_idx] = 1'b1;
      isr_d[win_idx]   = 1'b1;
    end
    int_d  = int_ok && !iack_re;
    cint_d = |crit_req;
    ext_d  = |ext_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      int_q  <= 1'b0;
      cint_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      int_q  <= int_d;
      cint_q <= cint_d;
      ext_q  <= ext_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tpr_q <= '0;
    else if (tpr_we) tpr_q <= tpr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spur_q <= SPUR_RST;
    else if (spur_we) spur_q <= spur_wdata;
  end

  assign int_o     = int_q;
  assign cint_o    = cint_q;
  assign ext_irq_o = ext_q;
  assign act_o     = pend_w | isr_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         iack_re,
  input logic         eoi_we,
  input logic         int_ok,
  input logic         int_o,
  input logic         cint_o,
  input logic [N-1:0] isr_q,
  input logic [N-1:0] pend_w,
  input logic [N-1:0] lvl_w
);
  assert_ack_drops_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iack_re |=> !int_o);

  assert_ack_sets_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_re && int_ok && !eoi_we) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  assert_spurious_keeps_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_re && !int_ok && !eoi_we) |=> $stable(isr_q));

  assert_eoi_retires_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_we && (isr_q != '0) && !(iack_re && int_ok)) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));

  assert_int_needs_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> $past(int_ok));

  assert_crit_level_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cint_o |-> ($past(pend_w & lvl_w) != '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .iack_re(iack_re), .eoi_we(eoi_we),
  .int_ok(int_ok), .int_o(int_o), .cint_o(cint_o), .isr_q(isr_q),
  .pend_w(pend_w), .lvl_w(lvl_w)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N = 8, PW = 4, VW = 8, IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          cfg_we, cfg_msk, cfg_lvl, tpr_we, spur_we, iack_re, eoi_we;
  logic [IW-1:0] cfg_sel;
  logic [PW-1:0] cfg_pri, tpr_wdata;
  logic [VW-1:0] cfg_vec, spur_wdata, iack_data;
  logic [1:0]    cfg_dst;
  logic          int_o, cint_o, ext_irq_o;
  logic [N-1:0]  act_o;
  int checks = 0, errors = 0;
  logic [VW-1:0] got;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.N(N), .PW(PW), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_pri(cfg_pri), .cfg_vec(cfg_vec), .cfg_msk(cfg_msk), .cfg_lvl(cfg_lvl),
    .cfg_dst(cfg_dst), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .spur_we(spur_we),
    .spur_wdata(spur_wdata), .iack_re(iack_re), .iack_data(iack_data),
    .eoi_we(eoi_we), .int_o(int_o), .cint_o(cint_o), .ext_irq_o(ext_irq_o),
    .act_o(act_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src = '0; cfg_we = 0; cfg_sel = '0; cfg_pri = '0; cfg_vec = '0;
    cfg_msk = 0; cfg_lvl = 0; cfg_dst = '0; tpr_we = 0; tpr_wdata = '0;
    spur_we = 0; spur_wdata = '0; iack_re = 0; eoi_we = 0;
    nclk(2);
    rst_n = 1'b1;
    nclk(1);
  endtask

  task automatic cfg(input int idx, input int pri, input int vec, input bit msk,
                     input bit lvl, input int dst);
    cfg_we = 1; cfg_sel = IW'(idx); cfg_pri = PW'(pri); cfg_vec = VW'(vec);
    cfg_msk = msk; cfg_lvl = lvl; cfg_dst = 2'(dst);
    nclk(1);
    cfg_we = 0;
  endtask

  task automatic set_tpr(input int t);
    tpr_we = 1; tpr_wdata = PW'(t);
    nclk(1);
    tpr_we = 0;
  endtask

  task automatic ack(output logic [VW-1:0] v);
    iack_re = 1; #1 v = iack_data;
    nclk(1);
    iack_re = 0;
  endtask

  task automatic eoi();
    eoi_we = 1;
    nclk(1);
    eoi_we = 0;
  endtask

  task automatic pulse(input int idx);
    src[idx] = 1'b1;
    nclk(1);
    src[idx] = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 int", int_o, 0);
    chk("R1 cint", cint_o, 0);
    chk("R1 ext", ext_irq_o, 0);
    chk("R1 act", act_o, 0);
    ack(got);
    chk("R1 spurious reset vector", got, 8'hFF);

    // R2 / R7 sweep: priority vs task priority, strict compare
    do_reset();
    src[0] = 1'b1;
    for (int p = 0; p < 16; p++) begin
      for (int t = 0; t < 16; t++) begin
        cfg_we = 1; cfg_sel = 0; cfg_pri = PW'(p); cfg_vec = 8'h40; cfg_msk = 0;
        cfg_lvl = 1; cfg_dst = 0; tpr_we = 1; tpr_wdata = PW'(t);
        nclk(1);
        cfg_we = 0; tpr_we = 0;
        nclk(1);
        chk("R2 R7 pri vs tpr", int_o, (p > t) ? 1 : 0);
      end
    end
    // R9 timing of a task priority change
    cfg(0, 5, 8'h40, 0, 1, 0);
    set_tpr(0);
    nclk(1);
    chk("R9 int before tpr", int_o, 1);
    set_tpr(5);
    chk("R9 int one clock after write still old", int_o, 1);
    nclk(1);
    chk("R9 int follows tpr", int_o, 0);
    set_tpr(0);
    nclk(1);
    // R7 / R9 mask
    cfg(0, 5, 8'h40, 1, 1, 0);
    nclk(1);
    chk("R7 masked source silent", int_o, 0);
    src[0] = 1'b0;

    // R3 selection sweep with ties
    do_reset();
    src = '1;
    for (int r = 0; r < 7; r++) begin
      int bestp, besti;
      bestp = -1; besti = 0;
      for (int i = 0; i < N; i++) begin
        int pr;
        pr = ((i * 5 + r * 3) % 7) + 1;
        cfg(i, pr, 8'h10 + i, 0, 1, 0);
        if (pr > bestp) begin bestp = pr; besti = i; end
      end
      nclk(2);
      ack(got);
      chk("R3 winner vector", got, 8'h10 + besti);
      eoi();
      nclk(1);
    end
    src = '0;

    // R4 / R8 / R11 / R6 edge source
    do_reset();
    cfg(1, 6, 8'h21, 0, 0, 0);
    pulse(1);
    nclk(1);
    chk("R2 edge int", int_o, 1);
    chk("R11 act pending", act_o[1], 1);
    ack(got);
    chk("R4 ack vector", got, 8'h21);
    chk("R4 int dropped", int_o, 0);
    chk("R11 act in service", act_o[1], 1);
    nclk(1);
    ack(got);
    chk("R8 edge pending cleared", got, 8'hFF);
    eoi();
    chk("R6 service ended", act_o[1], 0);
    nclk(1);
    chk("R8 no re-interrupt", int_o, 0);

    // R8 level source
    cfg(2, 6, 8'h22, 0, 1, 0);
    src[2] = 1'b1;
    nclk(2);
    ack(got);
    chk("R8 level vector", got, 8'h22);
    eoi();
    nclk(1);
    chk("R8 level re-presented", int_o, 1);
    ack(got);
    chk("R8 level second vector", got, 8'h22);
    src[2] = 1'b0;
    eoi();
    nclk(2);
    chk("R8 level released", int_o, 0);
    chk("R11 level idle", act_o[2], 0);

    // R12 / R6 nesting
    do_reset();
    cfg(3, 3, 8'h33, 0, 0, 0);
    cfg(4, 9, 8'h34, 0, 0, 0);
    cfg(5, 2, 8'h35, 0, 0, 0);
    pulse(3);
    nclk(1);
    ack(got);
    chk("R12 first vector", got, 8'h33);
    pulse(4);
    nclk(1);
    chk("R12 higher nests", int_o, 1);
    ack(got);
    chk("R12 nested vector", got, 8'h34);
    pulse(5);
    nclk(2);
    chk("R12 lower held off", int_o, 0);
    chk("R11 three active", act_o[5:3], 3'b111);
    eoi();
    chk("R6 highest retired first", act_o[5:3], 3'b101);
    eoi();
    chk("R6 second retired", act_o[5:3], 3'b100);
    nclk(1);
    chk("R12 held source presented", int_o, 1);
    ack(got);
    chk("R12 held vector", got, 8'h35);

    // R10 routing
    do_reset();
    cfg(6, 1, 8'h46, 0, 1, 1);
    cfg(7, 1, 8'h47, 0, 1, 2);
    src[6] = 1'b1; src[7] = 1'b1;
    nclk(2);
    chk("R10 critical", cint_o, 1);
    chk("R10 external", ext_irq_o, 1);
    chk("R10 core untouched", int_o, 0);
    cfg(6, 1, 8'h46, 0, 0, 1);
    nclk(1);
    chk("R10 edge on critical ignored", cint_o, 0);
    chk("R10 external still", ext_irq_o, 1);
    cfg(7, 0, 8'h47, 0, 1, 2);
    nclk(1);
    chk("R7 R10 priority zero on external", ext_irq_o, 0);
    src = '0;

    // R5 programmable spurious vector
    do_reset();
    spur_we = 1; spur_wdata = 8'h5A;
    nclk(1);
    spur_we = 0;
    cfg(0, 4, 8'h40, 1, 1, 0);
    src[0] = 1'b1;
    nclk(2);
    ack(got);
    chk("R5 spurious vector", got, 8'h5A);
    chk("R5 act only pending", act_o, 8'h01);
    cfg(0, 4, 8'h40, 0, 1, 0);
    nclk(1);
    chk("R5 service untouched so int rises", int_o, 1);
    src = '0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule